// File: doc/BRIEF.md
# Reference-Clock Prescaler and Binary Tick Generator

This block runs entirely in the domain of a slow reference oscillator and turns that oscillator into timing pulses for a real-time clock. It produces a one-second tick that drives the time-of-day counters. It also produces nine sampling ticks whose rates are the powers of two from 2 Hz up to 512 Hz. Software picks which of three reference rates is fitted with a two-bit select code, and one enable input gates the whole divider.

Each tick is a registered pulse one reference cycle wide. The rates are exact for all three references, including the two that are not powers of two. A phase accumulator adds 512 on every reference cycle and wraps modulo the reference rate. Each wrap is a 512 Hz step. A binary counter over those steps then yields every slower rate and the one-second tick. The tick vector is also laid out as a 16-bit event word, so that a downstream interrupt unit can latch each tick into a sticky status bit at a fixed position.

Top module: `rtc_tick_gen`

## Requirements
- R1: Select code 0 means a 32768 Hz reference, code 1 means 32000 Hz and code 2 means 38400 Hz. Code 3 is reserved: with code 3 no tick is produced and `running_o` is low, even while enable is high.
- R2: `running_o` is high exactly when enable is high and the select code is valid. While it is low, all divider state is cleared and no tick is produced. Enabling again restarts the counting from zero, so the first 512 Hz tick follows a full step period.
- R3: Every tick output is high for one reference cycle at a time and never on two cycles in a row.
- R4: Counting the cycles that follow the enabling edge, the first one-second window holds exactly N ticks of each N Hz output. The one-second tick falls exactly on reference cycle number F, where F is the reference rate in hertz.
- R5: The first 512 Hz tick is seen after 64, 63 or 75 enabled cycles for codes 0, 1 and 2, which is F/512 rounded up. Its spacing is a constant 64 cycles for code 0 and a constant 75 cycles for code 2. For code 1 it alternates between 62 and 63 cycles.
- R6: `tick_per_o[j]` carries the 2^(j+1) Hz rate. Whenever a slower tick fires, every faster tick fires in the same cycle. The one-second tick fires only together with all nine periodic ticks.
- R7: The event word `evt_o` has bit 4 for the one-second tick, bit 7 for 2 Hz, and bits 8 to 15 for 4 Hz to 512 Hz in ascending order. Bits 0 to 3, 5 and 6 are always zero.
- R8: Any change of the select code clears the divider on the first clock edge that samples the new code, so no runt tick can follow. The first 512 Hz tick then comes one step period after that clearing edge, which is 76 cycles after the change for code 2.
- R9: While reset is asserted, every tick output and the event word are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Reference oscillator clock; all logic runs on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Divider enable from the control register |
| ref_sel_i | input | 2 | Reference rate select code |
| running_o | output | 1 | Enable readback, qualified by a valid select code |
| tick_sec_o | output | 1 | One-second tick pulse |
| tick_per_o | output | 9 | Periodic ticks; bit j is 2^(j+1) Hz |
| evt_o | output | 16 | Ticks placed at their interrupt status bit positions |

## Verification
A wrong accumulator value, or a wrong modulus, moves the first 512 Hz tick and changes the tick spacing. It shows up within at most 76 reference cycles of enabling. A fault in the binary counter or in its tap logic breaks the coincidence between slower and faster ticks, or changes the tick count in a window. The first such sign appears within the first 2 Hz period, and the count is settled when the one-second tick falls off cycle F. A clear that is missed on a select change or on disable leaves a runt tick. That tick appears before the period that follows the clearing edge.

// File: rtl/rtc_tick_pkg.sv
package rtc_tick_pkg;

    typedef enum logic [1:0] {
        REF_SEL_A    = 2'd0,
        REF_SEL_B    = 2'd1,
        REF_SEL_C    = 2'd2,
        REF_SEL_RSVD = 2'd3
    } ref_sel_e;

    // positions in the downstream event / status word
    localparam int EVT_SEC_BIT  = 4;
    localparam int EVT_PER_BASE = 7;

endpackage

// File: rtl/rtc_ref_decode.sv
module rtc_ref_decode #(
    parameter int REF0_HZ = 32768,
    parameter int REF1_HZ = 32000,
    parameter int REF2_HZ = 38400,
    parameter int MOD_W   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable_i,
    input  logic [1:0]       sel_i,
    output logic [MOD_W-1:0] modulus_o,
    output logic             run_o,
    output logic             clear_o
);
    import rtc_tick_pkg::*;

    typedef struct packed {
        logic [1:0] sel;
    } dec_state_t;

    dec_state_t s_d, s_q;
    logic       valid_sel;

    always_comb begin
        s_d       = s_q;
        s_d.sel   = sel_i;
        valid_sel = 1'b1;
        modulus_o = MOD_W'(REF0_HZ);
        case (ref_sel_e'(sel_i))
            REF_SEL_A: modulus_o = MOD_W'(REF0_HZ);
            REF_SEL_B: modulus_o = MOD_W'(REF1_HZ);
            REF_SEL_C: modulus_o = MOD_W'(REF2_HZ);
            default:   valid_sel = 1'b0;
        endcase
        run_o   = enable_i && valid_sel;
        // a select change restarts the whole chain on this edge
        clear_o = !run_o || (sel_i != s_q.sel);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

endmodule

// File: rtl/rtc_phase_acc.sv
module rtc_phase_acc #(
    parameter int MOD_W = 16,
    parameter int STEP  = 512
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic [MOD_W-1:0] modulus_i,
    output logic             step_o
);
    localparam int SUM_W = MOD_W + 1;

    typedef struct packed {
        logic [MOD_W-1:0] acc;
    } acc_state_t;

    acc_state_t       s_d, s_q;
    logic [SUM_W-1:0] sum;

    always_comb begin
        s_d    = s_q;
        sum    = {1'b0, s_q.acc} + SUM_W'(STEP);
        step_o = !clear_i && (sum >= {1'b0, modulus_i});
        if (clear_i) begin
            s_d.acc = '0;
        end else if (step_o) begin
            s_d.acc = MOD_W'(sum - {1'b0, modulus_i});
        end else begin
            s_d.acc = MOD_W'(sum);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

endmodule

// File: rtl/rtc_tick_chain.sv
module rtc_tick_chain #(
    parameter int CHAIN_W = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear_i,
    input  logic               step_i,
    output logic [CHAIN_W-1:0] tick_per_o,
    output logic               tick_sec_o
);
    typedef struct packed {
        logic [CHAIN_W-1:0] cnt;
        logic [CHAIN_W-1:0] per;
        logic               sec;
    } chain_state_t;

    chain_state_t       s_d, s_q;
    logic [CHAIN_W-1:0] tap_hit;

    // tap j (rate 2^(j+1)) fires when the lower bits below it are all ones
    for (genvar j = 0; j < CHAIN_W; j++) begin : g_tap
        if (j == CHAIN_W - 1) begin : g_fast
            assign tap_hit[j] = 1'b1;
        end else begin : g_slow
            assign tap_hit[j] = &s_q.cnt[CHAIN_W-2-j:0];
        end
    end

    always_comb begin
        s_d = s_q;
        if (clear_i) begin
            s_d = '0;
        end else begin
            s_d.per = step_i ? tap_hit : '0;
            s_d.sec = step_i && (&s_q.cnt);
            if (step_i) s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign tick_per_o = s_q.per;
    assign tick_sec_o = s_q.sec;

endmodule

// File: rtl/rtc_tick_gen.sv
module rtc_tick_gen #(
    parameter int REF0_HZ     = 32768,
    parameter int REF1_HZ     = 32000,
    parameter int REF2_HZ     = 38400,
    parameter int TOP_TICK_HZ = 512
) (
    input  logic        clk_ref,
    input  logic        rst_n,
    input  logic        enable_i,
    input  logic [1:0]  ref_sel_i,
    output logic        running_o,
    output logic        tick_sec_o,
    output logic [$clog2(TOP_TICK_HZ)-1:0] tick_per_o,
    output logic [rtc_tick_pkg::EVT_PER_BASE+$clog2(TOP_TICK_HZ)-1:0] evt_o
);
    import rtc_tick_pkg::*;

    localparam int CHAIN_W = $clog2(TOP_TICK_HZ);
    localparam int MAX_HZ  = (REF0_HZ > REF1_HZ)
                           ? ((REF0_HZ > REF2_HZ) ? REF0_HZ : REF2_HZ)
                           : ((REF1_HZ > REF2_HZ) ? REF1_HZ : REF2_HZ);
    localparam int MOD_W   = $clog2(MAX_HZ + 1);
    localparam int EVT_W   = EVT_PER_BASE + CHAIN_W;

    logic [MOD_W-1:0] modulus;
    logic             clear;
    logic             step;

    rtc_ref_decode #(
        .REF0_HZ (REF0_HZ),
        .REF1_HZ (REF1_HZ),
        .REF2_HZ (REF2_HZ),
        .MOD_W   (MOD_W)
    ) i_decode (
        .clk       (clk_ref),
        .rst_n     (rst_n),
        .enable_i  (enable_i),
        .sel_i     (ref_sel_i),
        .modulus_o (modulus),
        .run_o     (running_o),
        .clear_o   (clear)
    );

    rtc_phase_acc #(
        .MOD_W (MOD_W),
        .STEP  (TOP_TICK_HZ)
    ) i_acc (
        .clk       (clk_ref),
        .rst_n     (rst_n),
        .clear_i   (clear),
        .modulus_i (modulus),
        .step_o    (step)
    );

    rtc_tick_chain #(
        .CHAIN_W (CHAIN_W)
    ) i_chain (
        .clk        (clk_ref),
        .rst_n      (rst_n),
        .clear_i    (clear),
        .step_i     (step),
        .tick_per_o (tick_per_o),
        .tick_sec_o (tick_sec_o)
    );

    always_comb begin
        evt_o                             = '0;
        evt_o[EVT_SEC_BIT]                = tick_sec_o;
        evt_o[EVT_PER_BASE +: CHAIN_W]    = tick_per_o;
    end

    logic unused_w;
    assign unused_w = ^EVT_W;

endmodule

// File: rtl/rtc_tick_gen_chk.sv
module rtc_tick_gen_chk #(
    parameter int CHAIN_W = 9
) (
    input logic               clk_ref,
    input logic               rst_n,
    input logic [1:0]         ref_sel_i,
    input logic               running_o,
    input logic               tick_sec_o,
    input logic [CHAIN_W-1:0] tick_per_o
);
    // R2: no tick follows a cycle in which the divider was not running
    a_r2_quiet_off: assert property (@(posedge clk_ref) disable iff (!rst_n)
        !running_o |=> (tick_per_o == '0) && !tick_sec_o);

    // R8: a select change leaves no tick behind it
    a_r8_restart_clean: assert property (@(posedge clk_ref) disable iff (!rst_n)
        !$stable(ref_sel_i) |=> (tick_per_o == '0) && !tick_sec_o);

    // R6: the one-second tick only with every periodic tick
    a_r6_sec_nested: assert property (@(posedge clk_ref) disable iff (!rst_n)
        tick_sec_o |-> (&tick_per_o));

    // R6: the slowest periodic tick implies the fastest one
    a_r6_slow_in_fast: assert property (@(posedge clk_ref) disable iff (!rst_n)
        tick_per_o[0] |-> tick_per_o[CHAIN_W-1]);

    // R3: the fastest tick never stays high for two cycles
    a_r3_single_pulse: assert property (@(posedge clk_ref) disable iff (!rst_n)
        tick_per_o[CHAIN_W-1] |=> !tick_per_o[CHAIN_W-1]);

endmodule

bind rtc_tick_gen rtc_tick_gen_chk #(.CHAIN_W(CHAIN_W)) i_chk (
    .clk_ref    (clk_ref),
    .rst_n      (rst_n),
    .ref_sel_i  (ref_sel_i),
    .running_o  (running_o),
    .tick_sec_o (tick_sec_o),
    .tick_per_o (tick_per_o)
);

// File: tb/test_rtc_tick_gen.sv
`timescale 1ns/1ps
module test_rtc_tick_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic [1:0]  sel = 2'd0;
    logic        running;
    logic        tsec;
    logic [8:0]  tper;
    logic [15:0] evt;

    int nchecks = 0;
    int nerrors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    rtc_tick_gen i_rtc_tick_gen (
        .clk_ref    (clk),
        .rst_n      (rst_n),
        .enable_i   (en),
        .ref_sel_i  (sel),
        .running_o  (running),
        .tick_sec_o (tsec),
        .tick_per_o (tper),
        .evt_o      (evt)
    );

    typedef struct packed {
        logic [1:0] code;
        int         hz;
        int         first;
        int         gmin;
        int         gmax;
    } row_t;

    localparam row_t ROWS [3] = '{
        '{2'd0, 32768, 64, 64, 64},
        '{2'd1, 32000, 63, 62, 63},
        '{2'd2, 38400, 75, 75, 75}
    };

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        nchecks++;
        if (!ok) begin
            nerrors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    // count cycles until the 512 Hz tick appears, limit 300
    task automatic wait_fast(output int n);
        n = 0;
        for (int i = 1; i <= 300; i++) begin
            cyc();
            if (tper[8]) begin
                n = i;
                break;
            end
        end
    endtask

    task automatic run_row(input row_t r);
        int cnt [9];
        int nsec, sec_idx, first, last, gmin, gmax, nest_bad, consec;
        logic [15:0] evt_first, evt_sec;
        logic [8:0] prev;
        en = 1'b0;
        sel = r.code;
        cyc(); cyc(); cyc();
        en = 1'b1;
        for (int j = 0; j < 9; j++) cnt[j] = 0;
        nsec = 0; sec_idx = 0; first = 0; last = 0; gmin = 1 << 20; gmax = 0;
        nest_bad = 0; consec = 0; evt_first = '0; evt_sec = '0; prev = '0;
        for (int i = 1; i <= r.hz; i++) begin
            cyc();
            for (int j = 0; j < 9; j++) if (tper[j]) cnt[j]++;
            for (int j = 0; j < 8; j++) if (tper[j] && !tper[j+1]) nest_bad++;
            if (tsec) begin
                nsec++;
                sec_idx = i;
                evt_sec = evt;
                if (tper != 9'h1FF) nest_bad++;
            end
            if ((tper & prev) != '0) consec++;
            prev = tper;
            if (tper[8]) begin
                if (first == 0) begin
                    first = i;
                    evt_first = evt;
                end else begin
                    if (i - last < gmin) gmin = i - last;
                    if (i - last > gmax) gmax = i - last;
                end
                last = i;
            end
        end
        for (int j = 0; j < 9; j++)
            check(cnt[j] == (2 << j), "R4", $sformatf("code %0d ticks at %0d Hz", r.code, 2 << j),
                  cnt[j], 2 << j);
        check(nsec == 1, "R4", "one-second tick count", nsec, 1);
        check(sec_idx == r.hz, "R4", "one-second tick cycle", sec_idx, r.hz);
        check(first == r.first, "R5", "first 512 Hz tick cycle", first, r.first);
        check(gmin == r.gmin, "R5", "min 512 Hz spacing", gmin, r.gmin);
        check(gmax == r.gmax, "R5", "max 512 Hz spacing", gmax, r.gmax);
        check(nest_bad == 0, "R6", "nesting violations", nest_bad, 0);
        check(consec == 0, "R3", "ticks on consecutive cycles", consec, 0);
        check(evt_first == 16'h8000, "R7", "event word at lone 512 Hz tick",
              int'(evt_first), 32'h8000);
        check(evt_sec == 16'hFF90, "R7", "event word at one-second tick",
              int'(evt_sec), 32'hFF90);
        check(running == 1'b1, "R2", "running readback while enabled", running, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nerrors++;
            $display("FAIL watchdog R1..: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrors);
            $finish;
        end
    end

    initial begin
        int n, seen;
        // R9: reset state
        repeat (3) cyc();
        check(tper == '0 && !tsec, "R9", "ticks during reset", int'(tper), 0);
        check(evt == '0, "R9", "event word during reset", int'(evt), 0);
        rst_n = 1'b1;
        cyc();

        // table walk over the three references
        for (int k = 0; k < 3; k++) run_row(ROWS[k]);

        // R2: disabled divider stays silent
        en = 1'b0; sel = 2'd0;
        seen = 0;
        for (int i = 0; i < 300; i++) begin
            cyc();
            if (tper != '0 || tsec) seen++;
        end
        check(seen == 0, "R2", "ticks while disabled", seen, 0);
        check(running == 1'b0, "R2", "running readback while disabled", running, 0);

        // R1: reserved code produces nothing
        sel = 2'd3; en = 1'b1;
        seen = 0;
        for (int i = 0; i < 300; i++) begin
            cyc();
            if (tper != '0 || tsec) seen++;
        end
        check(seen == 0, "R1", "ticks with reserved code", seen, 0);
        check(running == 1'b0, "R1", "running with reserved code", running, 0);

        // R8: select change restarts the chain
        en = 1'b0; sel = 2'd0;
        cyc(); cyc();
        en = 1'b1;
        repeat (100) cyc();
        sel = 2'd2;
        wait_fast(n);
        check(n == 76, "R8", "first tick after select change", n, 76);

        // R2: a one-cycle disable clears the accumulator
        repeat (40) cyc();
        en = 1'b0;
        cyc();
        en = 1'b1;
        wait_fast(n);
        check(n == 75, "R2", "first tick after re-enable", n, 75);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrors);
        $finish;
    end

endmodule